// File: doc/BRIEF.md
# Peripheral Bus Byte-Copy DMA Engine

This block moves a run of bytes between main memory and an external peripheral bus, in either direction, under control of a small write/read register window. Software loads a memory address register and a bus address register, then writes one of two length registers. The write to the first length register starts a copy from memory to the bus. The write to the second starts a copy from the bus to memory. The copy is byte-serial: each byte is fetched from the source side and then stored to the destination side, each step using a request/ready handshake.

When the last byte is stored, both address registers are written back with post-transfer values. The memory address is advanced and rounded up to a multiple of eight. The bus address is advanced and forced even. A timing counter then models the access cost of the bus domain. When it expires, busy drops and a one-cycle completion pulse is raised. When a 1-Mbit flash save mode is selected, a bus address inside the low 64 KiB of the save window is remapped by a left shift before the copy.

The controller is a state machine with six named states. ST_IDLE waits for a start. ST_FETCH requests the source byte. ST_PUT requests the destination store. ST_FIXUP writes back the addresses and loads the timer. ST_SETTLE counts the domain delay. ST_NOTIFY drops busy and pulses the completion output. The transitions are:
- ST_IDLE to ST_FETCH on an accepted start.
- ST_FETCH to ST_PUT on source ready.
- ST_PUT to ST_FETCH on destination ready while bytes remain.
- ST_PUT to ST_FIXUP on destination ready for the last byte.
- ST_FIXUP to ST_SETTLE, always.
- ST_SETTLE to ST_NOTIFY when the timer reads zero.
- ST_NOTIFY to ST_FETCH on a new start, otherwise to ST_IDLE.

Top module: `pbus_dma`

## Requirements
- R1: After reset, busy and done_irq are 0, no request is raised on either port, and every register (offsets 0x00, 0x04, 0x08, 0x0C, 0x10) reads 0.
- R2: The bus address register at offset 0x04 stores the written value with bit 0 cleared. The length registers at 0x08 and 0x0C keep only the low 24 bits of the written value. The memory address register at 0x00 keeps the low MEM_AW bits.
- R3: A write to offset 0x08 while not busy copies N = length+1 bytes, with memory byte at (mem address + i) stored to bus address (bus address + i) for i = 0..N-1.
- R4: A write to offset 0x0C while not busy copies N = length+1 bytes, with bus byte at (bus address + i) stored to memory address (mem address + i).
- R5: After a transfer, the memory address register reads (start + N) rounded up to the next multiple of 8.
- R6: After a transfer, the bus address register reads (start + N), plus 1 if that sum is odd.
- R7: With save_flash_mode high and a bus start address in [0x08000000, 0x08010000), the copy and the post-transfer update use 0x08000000 | ((address & 0xFFFFF) << 1). With the mode low, or with the address at 0x08010000 or above, the address is used unchanged.
- R8: busy rises in the cycle after an accepted length write and stays high through the copy and the delay. Bit 0 of the status register at 0x10 reads busy.
- R9: The settle delay is SETUP + PER_BYTE*N cycles. Domain 2 parameters apply when the (remapped) bus start address lies in [0x08000000, 0x10000000); domain 1 parameters apply otherwise. busy is high for 2*(copy handshake cycles) + delay + 2 cycles in total.
- R10: done_irq is a single-cycle pulse. It is raised exactly in the cycle in which busy falls.
- R11: A length write while busy is ignored. The length register keeps its old value and no second transfer starts.
- R12: A request holds its address and write flag stable until ready. Memory and bus are never requested in the same cycle, and neither is requested while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_flash_mode | input | 1 | Selects the 1-Mbit flash save address remap |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Memory request is a store |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | 8 | Memory store data |
| mem_rdata | input | 8 | Memory load data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory accepts the request this cycle |
| bus_req | output | 1 | Bus byte request |
| bus_we | output | 1 | Bus request is a store |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 8 | Bus store data |
| bus_rdata | input | 8 | Bus load data, valid with bus_rdy |
| bus_rdy | input | 1 | Bus accepts the request this cycle |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
An accepted length write is seen at the next clock edge, so busy is due one cycle after the write strobe. busy then stays high for two handshake phases per byte, plus one fixup cycle and delay+1 settle cycles. done_irq is due in the single cycle that follows. The bench's reference model counts these cycles from the same start edge, using the wait-state count it gives its own port models. It compares busy and done_irq on every falling edge, half a cycle after each update. Copied bytes and written-back addresses are checked only after the model reports completion, and register contents are read combinationally between edges.

// File: rtl/pbus_dma_pkg.sv
package pbus_dma_pkg;

    localparam int unsigned BUS_AW = 32;
    localparam logic [BUS_AW-1:0] SAVE_BASE   = 32'h0800_0000;
    localparam logic [BUS_AW-1:0] SAVE_REMAP_TOP = 32'h0801_0000;
    localparam logic [BUS_AW-1:0] DOM2_TOP    = 32'h1000_0000;
    localparam logic [BUS_AW-1:0] SAVE_LOW_MASK = 32'h000F_FFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PUT,
        ST_FIXUP,
        ST_SETTLE,
        ST_NOTIFY
    } dma_state_e;

    typedef enum logic {
        DIR_MEM_TO_BUS,
        DIR_BUS_TO_MEM
    } dma_dir_e;

    // Flash save window: low 20 bits shifted left, ORed with the window base.
    function automatic logic [BUS_AW-1:0] save_remap(input logic [BUS_AW-1:0] a,
                                                     input logic en);
        if (en && (a >= SAVE_BASE) && (a < SAVE_REMAP_TOP))
            return SAVE_BASE | ((a & SAVE_LOW_MASK) << 1);
        else
            return a;
    endfunction

    function automatic logic in_domain2(input logic [BUS_AW-1:0] a);
        return (a >= SAVE_BASE) && (a < DOM2_TOP);
    endfunction

endpackage

// File: rtl/pbus_dma_regs.sv
module pbus_dma_regs
    import pbus_dma_pkg::*;
#(
    parameter int unsigned MEM_AW = 24,
    parameter int unsigned LEN_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [4:0]           addr,
    input  logic [31:0]          wdata,
    input  logic                 engaged,
    input  logic                 upd,
    input  logic [MEM_AW-1:0]    upd_mem,
    input  logic [BUS_AW-1:0]    upd_bus,
    output logic [31:0]          rdata,
    output logic [MEM_AW-1:0]    mem_base,
    output logic [BUS_AW-1:0]    bus_base,
    output logic                 go_m2b,
    output logic                 go_b2m,
    output logic [LEN_W-1:0]     go_len
);

    localparam logic [4:0] OFS_MEM    = 5'h00;
    localparam logic [4:0] OFS_BUS    = 5'h04;
    localparam logic [4:0] OFS_M2B    = 5'h08;
    localparam logic [4:0] OFS_B2M    = 5'h0C;
    localparam logic [4:0] OFS_STATUS = 5'h10;

    logic [LEN_W-1:0] len_m2b_q;
    logic [LEN_W-1:0] len_b2m_q;
    logic             hit_m2b;
    logic             hit_b2m;

    assign hit_m2b = wr && (addr == OFS_M2B) && !engaged;
    assign hit_b2m = wr && (addr == OFS_B2M) && !engaged;
    assign go_m2b  = hit_m2b;
    assign go_b2m  = hit_b2m;
    assign go_len  = wdata[LEN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_base  <= '0;
            bus_base  <= '0;
            len_m2b_q <= '0;
            len_b2m_q <= '0;
        end else begin
            if (upd) begin
                mem_base <= upd_mem;
                bus_base <= upd_bus;
            end else if (wr) begin
                if (addr == OFS_MEM) mem_base <= wdata[MEM_AW-1:0];
                if (addr == OFS_BUS) bus_base <= {wdata[BUS_AW-1:1], 1'b0};
            end
            if (hit_m2b) len_m2b_q <= wdata[LEN_W-1:0];
            if (hit_b2m) len_b2m_q <= wdata[LEN_W-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            OFS_MEM:    rdata = 32'(mem_base);
            OFS_BUS:    rdata = bus_base;
            OFS_M2B:    rdata = 32'(len_m2b_q);
            OFS_B2M:    rdata = 32'(len_b2m_q);
            OFS_STATUS: rdata = {31'b0, engaged};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbus_dma_cost.sv
module pbus_dma_cost #(
    parameter int unsigned CNT_W       = 25,
    parameter int unsigned TMR_W       = 33,
    parameter int unsigned D1_SETUP    = 3,
    parameter int unsigned D1_PER_BYTE = 1,
    parameter int unsigned D2_SETUP    = 6,
    parameter int unsigned D2_PER_BYTE = 2
) (
    input  logic             dom2,
    input  logic [CNT_W-1:0] nbytes,
    output logic [TMR_W-1:0] delay
);

    localparam int unsigned NDOM = 2;

    logic [TMR_W-1:0] dom_cost [NDOM];

    // One cost term per domain, selected by the address domain.
    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        localparam int unsigned SETUP = (d == 0) ? D1_SETUP : D2_SETUP;
        localparam int unsigned PER   = (d == 0) ? D1_PER_BYTE : D2_PER_BYTE;
        assign dom_cost[d] = TMR_W'(SETUP) + TMR_W'(PER) * TMR_W'(nbytes);
    end

    assign delay = dom2 ? dom_cost[1] : dom_cost[0];

endmodule

// File: rtl/pbus_dma_timer.sv
module pbus_dma_timer #(
    parameter int unsigned TMR_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (run && cnt_q != '0)   cnt_q <= cnt_q - TMR_W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pbus_dma.sv
module pbus_dma
    import pbus_dma_pkg::*;
#(
    parameter int unsigned MEM_AW      = 24,
    parameter int unsigned LEN_W       = 24,
    parameter int unsigned D1_SETUP    = 3,
    parameter int unsigned D1_PER_BYTE = 1,
    parameter int unsigned D2_SETUP    = 6,
    parameter int unsigned D2_PER_BYTE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_flash_mode,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rdy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [31:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_rdy,
    output logic              busy,
    output logic              done_irq
);

    localparam int unsigned CNT_W = LEN_W + 1;
    localparam int unsigned TMR_W = CNT_W + 8;
    localparam logic [MEM_AW-1:0] ALIGN_ADD  = MEM_AW'(7);
    localparam logic [MEM_AW-1:0] ALIGN_MASK = ~MEM_AW'(7);

    dma_state_e state_q, state_d;

    dma_dir_e          dir_q;
    logic [MEM_AW-1:0] w_mem_q;
    logic [BUS_AW-1:0] w_bus_q;
    logic [CNT_W-1:0]  w_len_q;
    logic [CNT_W-1:0]  idx_q;
    logic [7:0]        byte_q;

    logic [MEM_AW-1:0] mem_base;
    logic [BUS_AW-1:0] bus_base;
    logic              go_m2b, go_b2m;
    logic [LEN_W-1:0]  go_len;
    logic              go;

    logic              src_rdy, dst_rdy;
    logic [7:0]        src_data;
    logic              last_byte;

    logic [MEM_AW-1:0] mem_end, mem_up;
    logic [BUS_AW-1:0] bus_end, bus_up;
    logic              fixup;
    logic [TMR_W-1:0]  delay;
    logic              tmr_zero;

    assign go = go_m2b || go_b2m;

    pbus_dma_regs #(
        .MEM_AW (MEM_AW),
        .LEN_W  (LEN_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .engaged  (busy),
        .upd      (fixup),
        .upd_mem  (mem_up),
        .upd_bus  (bus_up),
        .rdata    (reg_rdata),
        .mem_base (mem_base),
        .bus_base (bus_base),
        .go_m2b   (go_m2b),
        .go_b2m   (go_b2m),
        .go_len   (go_len)
    );

    pbus_dma_cost #(
        .CNT_W       (CNT_W),
        .TMR_W       (TMR_W),
        .D1_SETUP    (D1_SETUP),
        .D1_PER_BYTE (D1_PER_BYTE),
        .D2_SETUP    (D2_SETUP),
        .D2_PER_BYTE (D2_PER_BYTE)
    ) u_cost (
        .dom2   (in_domain2(w_bus_q)),
        .nbytes (w_len_q),
        .delay  (delay)
    );

    pbus_dma_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fixup),
        .load_val (delay),
        .run      (state_q == ST_SETTLE),
        .zero     (tmr_zero)
    );

    // Handshake side selection.
    assign src_rdy   = (dir_q == DIR_MEM_TO_BUS) ? mem_rdy : bus_rdy;
    assign dst_rdy   = (dir_q == DIR_MEM_TO_BUS) ? bus_rdy : mem_rdy;
    assign src_data  = (dir_q == DIR_MEM_TO_BUS) ? mem_rdata : bus_rdata;
    assign last_byte = (idx_q == w_len_q - CNT_W'(1));

    // Post-transfer address fixups.
    assign mem_end = w_mem_q + MEM_AW'(w_len_q);
    assign mem_up  = (mem_end + ALIGN_ADD) & ALIGN_MASK;
    assign bus_end = w_bus_q + BUS_AW'(w_len_q);
    assign bus_up  = bus_end + {{(BUS_AW-1){1'b0}}, bus_end[0]};
    assign fixup   = (state_q == ST_FIXUP);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_FETCH;
            ST_FETCH:  if (src_rdy) state_d = ST_PUT;
            ST_PUT:    if (dst_rdy) state_d = last_byte ? ST_FIXUP : ST_FETCH;
            ST_FIXUP:  state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_zero) state_d = ST_NOTIFY;
            ST_NOTIFY: state_d = go ? ST_FETCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Working copies of the transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= DIR_MEM_TO_BUS;
            w_mem_q <= '0;
            w_bus_q <= '0;
            w_len_q <= '0;
            idx_q   <= '0;
            byte_q  <= '0;
        end else begin
            if (go) begin
                dir_q   <= go_b2m ? DIR_BUS_TO_MEM : DIR_MEM_TO_BUS;
                w_mem_q <= mem_base;
                w_bus_q <= save_remap(bus_base, save_flash_mode);
                w_len_q <= CNT_W'(go_len) + CNT_W'(1);
                idx_q   <= '0;
            end else if (state_q == ST_PUT && dst_rdy) begin
                idx_q   <= idx_q + CNT_W'(1);
            end
            if (state_q == ST_FETCH && src_rdy)
                byte_q <= src_data;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        busy     = 1'b0;
        done_irq = 1'b0;
        mem_req  = 1'b0;
        bus_req  = 1'b0;
        mem_we   = 1'b0;
        bus_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                busy    = 1'b1;
                mem_req = (dir_q == DIR_MEM_TO_BUS);
                bus_req = (dir_q == DIR_BUS_TO_MEM);
            end
            ST_PUT: begin
                busy    = 1'b1;
                mem_req = (dir_q == DIR_BUS_TO_MEM);
                bus_req = (dir_q == DIR_MEM_TO_BUS);
                mem_we  = 1'b1;
                bus_we  = 1'b1;
            end
            ST_FIXUP:  busy = 1'b1;
            ST_SETTLE: busy = 1'b1;
            ST_NOTIFY: done_irq = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = w_mem_q + MEM_AW'(idx_q);
    assign bus_addr  = w_bus_q + BUS_AW'(idx_q);
    assign mem_wdata = byte_q;
    assign bus_wdata = byte_q;

endmodule

// File: rtl/pbus_dma_chk.sv
module pbus_dma_chk #(
    parameter int unsigned MEM_AW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [4:0]        reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_rdy,
    input logic              bus_req,
    input logic              bus_we,
    input logic [31:0]       bus_addr,
    input logic              bus_rdy,
    input logic              busy,
    input logic              done_irq
);

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !bus_req)); // R12

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && bus_req)); // R12

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R12

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R10

    AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $fell(busy)); // R10

    AST_FALL_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_irq); // R10

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && (reg_addr == 5'h08 || reg_addr == 5'h0C)) |=> busy); // R8

    AST_BUS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'h04) |-> !reg_rdata[0]); // R2

endmodule

bind pbus_dma pbus_dma_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rdy   (mem_rdy),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdy   (bus_rdy),
    .busy      (busy),
    .done_irq  (done_irq)
);

// File: tb/tb_pbus_dma.sv
`timescale 1ns/1ps
module tb_pbus_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        save_flash_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_rdy;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        bus_req, bus_we, bus_rdy;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        busy, done_irq;

    always #4 clk = ~clk; // 125 MHz

    pbus_dma dut (
        .clk(clk), .rst_n(rst_n), .save_flash_mode(save_flash_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .busy(busy), .done_irq(done_irq)
    );

    int checks = 0;
    int fails  = 0;
    int wait_n = 0;
    bit compare_on = 1'b0;

    // Behavioural port models.
    logic [7:0] mem_arr [4096];
    logic [7:0] bus_arr [4096];
    int mcnt = 0;
    int bcnt = 0;

    assign mem_rdy   = mem_req && (mcnt == wait_n);
    assign bus_rdy   = bus_req && (bcnt == wait_n);
    assign mem_rdata = mem_arr[mem_addr[11:0]];
    assign bus_rdata = bus_arr[bus_addr[11:0]];

    always @(posedge clk) begin
        if (mem_req && !mem_rdy) mcnt <= mcnt + 1; else mcnt <= 0;
        if (bus_req && !bus_rdy) bcnt <= bcnt + 1; else bcnt <= 0;
        if (mem_req && mem_we && mem_rdy) mem_arr[mem_addr[11:0]] = mem_wdata;
        if (bus_req && bus_we && bus_rdy) bus_arr[bus_addr[11:0]] = bus_wdata;
    end

    function automatic logic [31:0] ref_remap(logic [31:0] a, logic en);
        if (en && a >= 32'h0800_0000 && a < 32'h0801_0000)
            return 32'h0800_0000 | ((a & 32'h000F_FFFF) << 1);
        return a;
    endfunction

    function automatic int ref_delay(logic [31:0] a, int n);
        if (a >= 32'h0800_0000 && a < 32'h1000_0000) return 6 + 2 * n;
        return 3 + n;
    endfunction

    // Cycle-count reference model.
    bit          m_active = 1'b0;
    int          m_k = 0;
    int          m_B = 0;
    logic [31:0] m_mem = '0;
    logic [31:0] m_bus = '0;

    always @(posedge clk) begin
        bit mb;
        int n;
        logic [31:0] rb;
        if (!rst_n) begin
            m_active = 1'b0; m_k = 0; m_mem = '0; m_bus = '0;
        end else begin
            mb = m_active && (m_k <= m_B);
            if (m_active) begin
                m_k++;
                if (m_k > m_B + 1) m_active = 1'b0;
            end
            if (reg_wr && reg_addr == 5'h00) m_mem = reg_wdata & 32'h00FF_FFFF;
            if (reg_wr && reg_addr == 5'h04) m_bus = reg_wdata & 32'hFFFF_FFFE;
            if (reg_wr && !mb && (reg_addr == 5'h08 || reg_addr == 5'h0C)) begin
                n  = int'(reg_wdata & 32'h00FF_FFFF) + 1;
                rb = ref_remap(m_bus, save_flash_mode);
                m_B = 2 * n * (wait_n + 1) + ref_delay(rb, n) + 2;
                m_active = 1'b1;
                m_k = 1;
                m_mem = ((m_mem + n + 7) & 32'hFFFF_FFF8) & 32'h00FF_FFFF;
                m_bus = rb + n;
                if (m_bus[0]) m_bus = m_bus + 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Per-clock comparison of busy and done_irq (R8, R9, R10).
    always @(negedge clk) begin
        if (compare_on) begin
            check("R9 busy", {31'b0, busy}, {31'b0, (m_active && m_k <= m_B)});
            check("R10 done_irq", {31'b0, done_irq}, {31'b0, (m_active && m_k == m_B + 1)});
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [4:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!m_active) break;
        end
    endtask

    // One transfer: program addresses, start, wait, check bytes and addresses.
    task automatic run(string req, bit b2m, logic [31:0] ma, logic [31:0] ba,
                       logic [31:0] lenval, int w, bit flash);
        logic [7:0]  exp [64];
        logic [31:0] rb;
        int          n;
        logic [31:0] dst;
        wait_n = w;
        save_flash_mode = flash;
        wr(5'h00, ma);
        wr(5'h04, ba);
        rb = ref_remap(ba & 32'hFFFF_FFFE, flash);
        n  = int'(lenval & 32'h00FF_FFFF) + 1;
        for (int i = 0; i < n; i++)
            exp[i] = b2m ? bus_arr[(rb + i) & 32'hFFF] : mem_arr[(ma + i) & 32'hFFF];
        wr(b2m ? 5'h0C : 5'h08, lenval);
        rd_check("R8 status busy", 5'h10, 32'h1);
        wait_done();
        for (int i = 0; i < n; i++) begin
            dst = b2m ? {24'b0, mem_arr[(ma + i) & 32'hFFF]} : {24'b0, bus_arr[(rb + i) & 32'hFFF]};
            check(req, dst, {24'b0, exp[i]});
        end
        rd_check("R5 mem address post", 5'h00, m_mem);
        rd_check("R6 bus address post", 5'h04, m_bus);
        rd_check("R8 status idle", 5'h10, 32'h0);
    endtask

    initial begin
        logic [7:0] snap [8];
        for (int i = 0; i < 4096; i++) begin
            mem_arr[i] = 8'((i * 7 + 3) & 255);
            bus_arr[i] = 8'((i * 13 + 90) & 255);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {31'b0, busy}, 32'h0);
        check("R1 done_irq", {31'b0, done_irq}, 32'h0);
        check("R1 no request", {30'b0, mem_req, bus_req}, 32'h0);
        rd_check("R1 reg 00", 5'h00, 32'h0);
        rd_check("R1 reg 04", 5'h04, 32'h0);
        rd_check("R1 reg 08", 5'h08, 32'h0);
        rd_check("R1 reg 0C", 5'h0C, 32'h0);
        rd_check("R1 reg 10", 5'h10, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_on = 1'b1;

        // R2: bus address bit 0 cleared
        wr(5'h04, 32'h0000_0123);
        rd_check("R2 bus addr even", 5'h04, 32'h0000_0122);

        // R3, R5, R6: memory to bus, odd bus end
        run("R3 m2b bytes", 1'b0, 32'h10, 32'h102, 32'h4, 0, 1'b0);
        // R4: bus to memory with wait states, aligned memory end
        run("R4 b2m bytes", 1'b1, 32'h21, 32'h200, 32'h6, 2, 1'b0);
        // R2: length keeps low 24 bits
        run("R3 m2b masked length", 1'b0, 32'h40, 32'h300, 32'hFF00_0003, 0, 1'b0);
        rd_check("R2 length low 24 bits", 5'h08, 32'h0000_0003);
        // R7: remap active
        run("R7 remap on", 1'b0, 32'h60, 32'h0800_0100, 32'h1, 0, 1'b1);
        check("R7 remapped post bus", m_bus, 32'h0800_0202);
        // R7: remap off by mode
        run("R7 remap off", 1'b1, 32'h80, 32'h0800_0100, 32'h2, 1, 1'b0);
        check("R7 unmapped post bus", m_bus, 32'h0800_0104);
        // R7: address at window limit is not remapped
        run("R7 above window", 1'b0, 32'h90, 32'h0801_0000, 32'h1, 0, 1'b1);
        check("R7 limit post bus", m_bus, 32'h0801_0002);

        // R11: length write while busy is ignored
        save_flash_mode = 1'b0;
        wait_n = 0;
        wr(5'h00, 32'hA0);
        wr(5'h04, 32'h400);
        for (int i = 0; i < 8; i++) snap[i] = mem_arr[12'hA8 + i];
        wr(5'h08, 32'h2);
        wr(5'h0C, 32'h55);
        rd_check("R11 length unchanged", 5'h0C, 32'h0000_0002);
        wait_done();
        repeat (3) @(negedge clk);
        check("R11 no second transfer", {31'b0, busy}, 32'h0);
        for (int i = 0; i < 8; i++)
            check("R11 memory untouched", {24'b0, mem_arr[12'hA8 + i]}, {24'b0, snap[i]});
        check("R11 copied byte", {24'b0, bus_arr[12'h400]}, {24'b0, mem_arr[12'hA0]});

        repeat (4) @(negedge clk);
        compare_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule